// File: doc/BRIEF.md
# Same-Class Instruction Gap Histogram

This block is a performance monitor that sits beside a core's retirement stage. At most one instruction retires per cycle, and each arrives with a two-bit class code that an upstream decoder has already assigned. Loads of every access size share one class, stores of every size share another, and conditional branches have a third. Every other instruction carries the fourth code.

For each of the three tracked classes, the block measures the distance between consecutive members of that class. The distance is the number of retirements that fall strictly between the two members, so two members retiring back to back are at distance zero. Each measured distance adds one to a bin of that class's histogram. Distances 0 to 14 each have their own bin, and every distance of 15 or more goes into a shared overflow bin (bin 15).

Each class runs a small tracker state machine with two states. `TRK_IDLE` means the class is disarmed. `TRK_ARMED` means a member has been seen and the gap counter is live. The transitions are as follows:
- `TRK_IDLE -> TRK_ARMED` is taken on the first member of the class.
- `TRK_ARMED -> TRK_ARMED` is taken on every later member, and that retirement records the gap.
- Any state goes to `TRK_IDLE` on a synchronous clear.

Software reads a bin by giving a class select and a bin index. The count appears on the next cycle.

Top module: `gap_hist_monitor`

## Requirements
- R1: Class codes on `ret_cls` and `rd_cls` are 2'b01 load, 2'b10 store, 2'b11 conditional branch and 2'b00 other. A read with `rd_cls` = 2'b00 returns zero.
- R2: The distance recorded for a class is the number of retirements strictly between two consecutive members of that class, and back-to-back members record distance 0.
- R3: Distances 0 through 14 increment bins 0 through 14 of that class. A distance of 15 or more increments bin 15.
- R4: The first member of a class after reset or clear records no bin. It only arms the class (`TRK_IDLE -> TRK_ARMED`).
- R5: The gap counter of an armed class saturates at 15, so any run of other instructions, however long, lands in bin 15 and never wraps to a small bin.
- R6: A retirement of one class changes no other class's histogram, although it advances the other armed classes' gaps by one. A cycle without `ret_vld` advances no gap.
- R7: Bin counters are `CNT_W` bits wide (default 32) and hold at their maximum value instead of wrapping.
- R8: A synchronous clear zeroes every bin and returns every class to `TRK_IDLE`. A retirement in the same cycle as the clear is discarded.
- R9: `rd_data` shows the selected bin one cycle after the request. If that bin is updated in the request cycle, `rd_data` shows the value from before the update.
- R10: After reset every bin reads zero and every class is disarmed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr | input | 1 | Synchronous clear of all bins and trackers |
| ret_vld | input | 1 | One instruction retires this cycle |
| ret_cls | input | 2 | Class of the retiring instruction |
| rd_cls | input | 2 | Class select for the read port |
| rd_bin | input | GAP_W | Bin index for the read port |
| rd_data | output | CNT_W | Bin count, one cycle after the request |

## Verification
The hardest condition to reach from the ports is counter saturation. At the default width it cannot be reached in any practical run, so the bench builds the block with 8-bit bins and drives hundreds of back-to-back loads into bin 0. It also drives long runs of other instructions, well past 15, to push a gap counter into its own saturation.

Two same-cycle corner cases are also forced:
- a read of exactly the bin being updated;
- a clear that coincides with a retirement.

A long mixed stream that includes idle cycles then runs against a behavioural model.

// File: rtl/gap_hist_pkg.sv
package gap_hist_pkg;

    typedef enum logic [1:0] {
        CLS_OTHER  = 2'b00,
        CLS_LOAD   = 2'b01,
        CLS_STORE  = 2'b10,
        CLS_BRANCH = 2'b11
    } ret_class_e;

    typedef enum logic {
        TRK_IDLE  = 1'b0,
        TRK_ARMED = 1'b1
    } trk_state_e;

    localparam int NUM_TRACKED = 3;

endpackage

// File: rtl/gap_tracker.sv
module gap_tracker
    import gap_hist_pkg::*;
#(
    parameter int         GAP_W    = 4,
    parameter logic [1:0] CLS_CODE = 2'b01
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             ret_vld,
    input  logic [1:0]       ret_cls,
    output logic             rec_vld,
    output logic [GAP_W-1:0] rec_bin
);

    localparam logic [GAP_W-1:0] GAP_MAX = {GAP_W{1'b1}};

    trk_state_e       state_q, state_d;
    logic [GAP_W-1:0] gap_q, gap_d;
    logic             hit;

    assign hit = ret_vld && (ret_cls == CLS_CODE);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= TRK_IDLE;
            gap_q   <= '0;
        end else begin
            state_q <= state_d;
            gap_q   <= gap_d;
        end
    end

    // next state and gap counter
    always_comb begin
        state_d = state_q;
        gap_d   = gap_q;
        if (clr) begin
            state_d = TRK_IDLE;
            gap_d   = '0;
        end else begin
            unique case (state_q)
                TRK_IDLE: begin
                    if (hit) begin
                        state_d = TRK_ARMED;
                        gap_d   = '0;
                    end
                end
                TRK_ARMED: begin
                    if (hit) begin
                        gap_d = '0;
                    end else if (ret_vld && gap_q != GAP_MAX) begin
                        gap_d = gap_q + 1'b1;
                    end
                end
            endcase
        end
    end

    // outputs
    always_comb begin
        rec_vld = 1'b0;
        rec_bin = gap_q;
        unique case (state_q)
            TRK_IDLE:  rec_vld = 1'b0;
            TRK_ARMED: rec_vld = hit && !clr;
        endcase
    end

    p_first_arm_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == TRK_IDLE && hit && !clr) |=> (state_q == TRK_ARMED && gap_q == '0));

    p_gap_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == TRK_ARMED && gap_q == GAP_MAX && ret_vld && !hit && !clr) |=> gap_q == GAP_MAX);

    p_idle_cycle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!ret_vld && !clr) |=> ($stable(gap_q) && $stable(state_q)));

    p_clear_disarm_r8: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (state_q == TRK_IDLE && gap_q == '0));

endmodule

// File: rtl/hist_bank.sv
module hist_bank #(
    parameter int GAP_W = 4,
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             rec_vld,
    input  logic [GAP_W-1:0] rec_bin,
    input  logic [GAP_W-1:0] rd_bin,
    output logic [CNT_W-1:0] rd_val
);

    localparam int               NUM_BINS = 2 ** GAP_W;
    localparam logic [CNT_W-1:0] CNT_MAX  = {CNT_W{1'b1}};

    logic [CNT_W-1:0] bins_q [NUM_BINS];

    for (genvar b = 0; b < NUM_BINS; b++) begin : g_bin
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                bins_q[b] <= '0;
            end else if (clr) begin
                bins_q[b] <= '0;
            end else if (rec_vld && rec_bin == GAP_W'(b) && bins_q[b] != CNT_MAX) begin
                bins_q[b] <= bins_q[b] + 1'b1;
            end
        end

        p_bin_sat_r7: assert property (@(posedge clk) disable iff (!rst_n)
            (bins_q[b] == CNT_MAX && !clr) |=> bins_q[b] == CNT_MAX);

        p_bin_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
            clr |=> bins_q[b] == '0);

        p_bin_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
            !clr |=> (bins_q[b] == $past(bins_q[b]) || bins_q[b] == $past(bins_q[b]) + 1'b1));
    end

    assign rd_val = bins_q[rd_bin];

endmodule

// File: rtl/gap_hist_monitor.sv
module gap_hist_monitor
    import gap_hist_pkg::*;
#(
    parameter int GAP_W = 4,
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             ret_vld,
    input  logic [1:0]       ret_cls,
    input  logic [1:0]       rd_cls,
    input  logic [GAP_W-1:0] rd_bin,
    output logic [CNT_W-1:0] rd_data
);

    logic [NUM_TRACKED-1:0] rec_vld;
    logic [GAP_W-1:0]       rec_bin [NUM_TRACKED];
    logic [CNT_W-1:0]       bank_rd [NUM_TRACKED];
    logic [CNT_W-1:0]       rd_q;

    for (genvar k = 0; k < NUM_TRACKED; k++) begin : g_cls
        gap_tracker #(
            .GAP_W   (GAP_W),
            .CLS_CODE(2'(k + 1))
        ) i_trk (
            .clk    (clk),
            .rst_n  (rst_n),
            .clr    (clr),
            .ret_vld(ret_vld),
            .ret_cls(ret_cls),
            .rec_vld(rec_vld[k]),
            .rec_bin(rec_bin[k])
        );

        hist_bank #(
            .GAP_W(GAP_W),
            .CNT_W(CNT_W)
        ) i_bank (
            .clk    (clk),
            .rst_n  (rst_n),
            .clr    (clr),
            .rec_vld(rec_vld[k]),
            .rec_bin(rec_bin[k]),
            .rd_bin (rd_bin),
            .rd_val (bank_rd[k])
        );
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_q <= '0;
        end else begin
            unique case (rd_cls)
                CLS_LOAD:   rd_q <= bank_rd[0];
                CLS_STORE:  rd_q <= bank_rd[1];
                CLS_BRANCH: rd_q <= bank_rd[2];
                default:    rd_q <= '0;
            endcase
        end
    end

    assign rd_data = rd_q;

    p_one_record_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(rec_vld));

    p_clear_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        clr |-> rec_vld == '0);

    p_other_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_vld && ret_cls == CLS_OTHER) |-> rec_vld == '0);

    p_no_cls_read_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_cls == CLS_OTHER) |=> rd_data == '0);

endmodule

// File: tb/test_gap_hist_monitor.sv
module test_gap_hist_monitor;

    localparam int GAP_W = 4;
    localparam int CNT_W = 8;
    localparam int CMAX  = (1 << CNT_W) - 1;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             clr = 1'b0;
    logic             ret_vld = 1'b0;
    logic [1:0]       ret_cls = 2'b00;
    logic [1:0]       rd_cls = 2'b00;
    logic [GAP_W-1:0] rd_bin = '0;
    logic [CNT_W-1:0] rd_data;

    int checks = 0;
    int errors = 0;

    int bins_m [3][16];
    int gap_m  [3];
    bit armed_m[3];
    int rptr = 0;

    always #5 clk = ~clk;

    gap_hist_monitor #(.GAP_W(GAP_W), .CNT_W(CNT_W)) i_gap_hist_monitor (
        .clk(clk), .rst_n(rst_n), .clr(clr), .ret_vld(ret_vld), .ret_cls(ret_cls),
        .rd_cls(rd_cls), .rd_bin(rd_bin), .rd_data(rd_data)
    );

    task automatic model_clear();
        for (int c = 0; c < 3; c++) begin
            gap_m[c] = 0;
            armed_m[c] = 1'b0;
            for (int b = 0; b < 16; b++) bins_m[c][b] = 0;
        end
    endtask

    // one clock: drive, predict read (pre-update), update model, compare
    task automatic step(input bit v, input logic [1:0] c, input bit cl,
                        input logic [1:0] rc, input logic [3:0] rb, input string tag);
        int exp_rd;
        ret_vld = v; ret_cls = c; clr = cl; rd_cls = rc; rd_bin = rb;
        exp_rd = (rc == 2'b00) ? 0 : bins_m[rc-1][rb];
        if (cl) begin
            model_clear();
        end else if (v) begin
            for (int k = 0; k < 3; k++) begin
                if (c == 2'(k + 1)) begin
                    if (armed_m[k]) begin
                        int bi;
                        bi = (gap_m[k] > 15) ? 15 : gap_m[k];
                        if (bins_m[k][bi] < CMAX) bins_m[k][bi]++;
                    end
                    armed_m[k] = 1'b1;
                    gap_m[k] = 0;
                end else if (armed_m[k]) begin
                    gap_m[k] = gap_m[k] + 1;
                end
            end
        end
        @(posedge clk);
        #2;
        checks++;
        if (int'(rd_data) != exp_rd) begin
            errors++;
            $display("FAIL %s cls=%0d bin=%0d actual=%0d expected=%0d", tag, rc, rb, rd_data, exp_rd);
        end
    endtask

    task automatic ret(input logic [1:0] c, input string tag);
        logic [1:0] rc;
        rc = 2'(1 + (rptr % 3));
        step(1'b1, c, 1'b0, rc, 4'(rptr / 3), tag);
        rptr = (rptr + 1) % 48;
    endtask

    task automatic dump_all(input string tag);
        for (int c = 1; c <= 3; c++)
            for (int b = 0; b < 16; b++)
                step(1'b0, 2'b00, 1'b0, 2'(c), 4'(b), tag);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        model_clear();
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;

        // R10: reset state
        dump_all("R10");
        // R1: class 00 read returns zero
        step(1'b0, 2'b00, 1'b0, 2'b00, 4'd3, "R1");

        // R4 / R2: first load arms only, then distance 0 and 2
        ret(2'b01, "R4");
        ret(2'b01, "R2");
        ret(2'b00, "R2"); ret(2'b00, "R2");
        ret(2'b01, "R2");
        dump_all("R2");

        // R3: store distances 14, 15, 20
        ret(2'b10, "R3");
        repeat (14) ret(2'b00, "R3");
        ret(2'b10, "R3");
        repeat (15) ret(2'b00, "R3");
        ret(2'b10, "R3");
        repeat (20) ret(2'b01, "R3");
        ret(2'b10, "R3");
        dump_all("R3");

        // R5: long run of others before a branch
        ret(2'b11, "R5");
        repeat (40) ret(2'b00, "R5");
        ret(2'b11, "R5");
        dump_all("R5");

        // R6: idle cycles do not advance gaps
        ret(2'b11, "R6");
        repeat (10) step(1'b0, 2'b11, 1'b0, 2'b11, 4'd0, "R6");
        ret(2'b11, "R6");
        dump_all("R6");

        // R9: read the very bin being updated
        step(1'b1, 2'b01, 1'b0, 2'b01, 4'd0, "R9");
        step(1'b1, 2'b01, 1'b0, 2'b01, 4'd0, "R9");
        step(1'b0, 2'b00, 1'b0, 2'b01, 4'd0, "R9");

        // R7: saturate load bin 0
        for (int i = 0; i < 300; i++) step(1'b1, 2'b01, 1'b0, 2'b01, 4'd0, "R7");
        step(1'b0, 2'b00, 1'b0, 2'b01, 4'd0, "R7");

        // R8: clear together with a retirement, then R4 after clear
        step(1'b1, 2'b01, 1'b1, 2'b01, 4'd0, "R8");
        dump_all("R8");
        ret(2'b10, "R4");
        ret(2'b01, "R4");
        dump_all("R4");

        // mixed stream with idle cycles
        for (int i = 0; i < 3000; i++) begin
            bit v;
            v = ($urandom % 5) != 0;
            step(v, 2'($urandom % 4), ($urandom % 700) == 0,
                 2'($urandom % 4), 4'($urandom % 16), "R2");
        end
        dump_all("R3");

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule